// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with two timeout stages, driven by a slow tick enable. Software loads a 16-bit timeout value. The block then counts it down, once for every 2^p ticks, where p is a prescaler field. When the first stage expires, the block performs that stage's programmed action, raises an overflow flag, reloads the count and starts the second stage. When the second stage expires, it performs the second stage's action and stops until software loads the timeout again.

Each stage has its own 2-bit action code. A code can do nothing, raise an interrupt request, raise a system-management interrupt request or ask for a system reset. Each action sets a sticky status flag, and the matching request output follows that flag. The flags clear in an unusual way. Writing 1 to the overflow bit clears only the overflow flag. Writing 0 to the overflow bit clears only the three action flags.

The stage sequencer has four states:

| State | Meaning |
|---|---|
| ST_OFF | Timeout is zero; nothing counts. |
| ST_STAGE1 | Counting the first stage. |
| ST_STAGE2 | Counting the second stage. |
| ST_SPENT | Both stages have expired; waiting for a reload. |

The transitions are:

| Transition | Cause |
|---|---|
| LOAD | A write to the timeout register. Goes to ST_STAGE1 for a nonzero value and to ST_OFF for zero. This works from every state. |
| EXPIRE1 | ST_STAGE1 goes to ST_STAGE2. |
| EXPIRE2 | ST_STAGE2 goes to ST_SPENT. |

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, the timeout, configuration and status registers all read 0, and irq_o, smi_o and rst_req_o are low.
- R2: The registers sit at byte addresses 0x0 (timeout, 16 bits), 0x2 (configuration) and 0x4 (status, 8 bits, read in rd_data_o[7:0] with the upper bits 0). rd_data_o is a combinational read of addr_i.
- R3: Configuration bits 3:0 hold the prescaler p, and the counter steps once every 2^p ticks. Writing 0xE or 0xF stores 0xD.
- R4: Configuration bits 15:9 always read 0, and writes to them are ignored. While configuration bit 8 is 1, ticks are ignored and nothing counts.
- R5: A write to the timeout register loads the counter and enters stage 1, from any state. This includes stage 2 and the spent state. A value of 0 disables counting.
- R6: Stage 1 expires on the tick that completes timeout×2^p ticks after the load. At that point it performs the stage-1 action (configuration bits 5:4), sets status bit 0 (overflow), reloads the counter and enters stage 2.
- R7: Stage 2 expires after another timeout×2^p ticks. It performs the stage-2 action (configuration bits 7:6) and leaves status bit 0 unchanged. After that, nothing happens until the next load.
- R8: The action codes are: 00 = none, 01 = interrupt (sets status bit 1), 10 = SMI (sets status bit 2), 11 = reset (sets status bit 3). irq_o, smi_o and rst_req_o equal status bits 1, 2 and 3.
- R9: A status write with bit 0 = 1 clears only bit 0. A status write with bit 0 = 0 clears only bits 3:1. Status bits 7:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| tick_i | input | 1 | Slow count-clock enable, one cycle per tick |
| addr_i | input | 3 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request |
| smi_o | output | 1 | System-management interrupt request |
| rst_req_o | output | 1 | System reset request |

## Verification
The bench uses the default parameters: a 16-bit counter and a 4-bit prescaler field whose largest legal value is 13. With these values, the clamp of the reserved prescaler codes can be seen directly at the register port. Short timeouts of 1 to 3 with prescalers 0 and 2 keep each stage expiry within a few ticks. This brings both stages, all four action codes, reloads in mid-stage, power-down and both status-clear rules within a short run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_STAGE1 = 2'd1,
        ST_STAGE2 = 2'd2,
        ST_SPENT  = 2'd3
    } wdt_stage_t;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'b00,
        ACT_IRQ   = 2'b01,
        ACT_SMI   = 2'b10,
        ACT_RESET = 2'b11
    } wdt_action_t;

    localparam logic [2:0] ADR_TIMEOUT = 3'h0;
    localparam logic [2:0] ADR_CONFIG  = 3'h2;
    localparam logic [2:0] ADR_STATUS  = 3'h4;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRES_W   = 4,
    parameter int PRES_MAX = 13,
    localparam int DIV_W   = (PRES_MAX > 0) ? PRES_MAX : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              clear_i,
    input  logic [PRES_W-1:0] pres_i,
    output logic              step_o
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < DIV_W; i++) begin
            if (i < int'(pres_i)) mask[i] = 1'b1;
        end
    end

    assign step_o = tick_i && ((div_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_q <= '0;
        else if (clear_i) div_q <= '0;
        else if (tick_i)  div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/wdt_stage_fsm.sv
module wdt_stage_fsm
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] reload_val_i,
    input  logic             step_i,
    output logic             fire1_o,
    output logic             fire2_o,
    output wdt_stage_t       stage_o
);
    wdt_stage_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = step_i && (cnt_q == CNT_W'(1));

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = (load_val_i == '0) ? ST_OFF : ST_STAGE1;
        end else begin
            unique case (state_q)
                ST_OFF:    state_d = ST_OFF;
                ST_STAGE1: if (at_end) state_d = ST_STAGE2;
                ST_STAGE2: if (at_end) state_d = ST_SPENT;
                ST_SPENT:  state_d = ST_SPENT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (step_i && (state_q == ST_STAGE1 || state_q == ST_STAGE2)) begin
            if (cnt_q == CNT_W'(1) && state_q == ST_STAGE1) cnt_q <= reload_val_i;
            else                                            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        fire1_o = 1'b0;
        fire2_o = 1'b0;
        unique case (state_q)
            ST_OFF:    ;
            ST_STAGE1: fire1_o = at_end && !load_i;
            ST_STAGE2: fire2_o = at_end && !load_i;
            ST_SPENT:  ;
        endcase
    end

    assign stage_o = state_q;
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PRES_W   = 4,
    parameter int PRES_MAX = 13,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [15:0]       wr_data_i,
    output logic [15:0]       rd_data_o,
    output logic              irq_o,
    output logic              smi_o,
    output logic              rst_req_o
);
    logic [CNT_W-1:0]  timeout_q;
    logic [PRES_W-1:0] pres_q;
    wdt_action_t       act1_q, act2_q;
    logic              pd_q;
    logic              ovf_q, irq_q, smi_q, rstf_q;

    logic wr_tmo, wr_cfg, wr_sts;
    logic step, fire1, fire2, eff_tick;
    wdt_action_t fired;
    wdt_stage_t  stage;

    assign wr_tmo   = wr_en_i && (addr_i == ADDR_W'(ADR_TIMEOUT));
    assign wr_cfg   = wr_en_i && (addr_i == ADDR_W'(ADR_CONFIG));
    assign wr_sts   = wr_en_i && (addr_i == ADDR_W'(ADR_STATUS));
    assign eff_tick = tick_i && !pd_q;

    wdt_prescaler #(.PRES_W(PRES_W), .PRES_MAX(PRES_MAX)) u_pres (
        .clk(clk), .rst_n(rst_n), .tick_i(eff_tick), .clear_i(wr_tmo),
        .pres_i(pres_q), .step_o(step)
    );

    wdt_stage_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .load_i(wr_tmo),
        .load_val_i(wr_data_i[CNT_W-1:0]), .reload_val_i(timeout_q),
        .step_i(step), .fire1_o(fire1), .fire2_o(fire2), .stage_o(stage)
    );

    always_comb begin
        fired = ACT_NONE;
        if (fire1)      fired = act1_q;
        else if (fire2) fired = act2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timeout_q <= '0;
            pres_q    <= '0;
            act1_q    <= ACT_NONE;
            act2_q    <= ACT_NONE;
            pd_q      <= 1'b0;
        end else begin
            if (wr_tmo) timeout_q <= wr_data_i[CNT_W-1:0];
            if (wr_cfg) begin
                pres_q <= (wr_data_i[PRES_W-1:0] > PRES_W'(PRES_MAX))
                          ? PRES_W'(PRES_MAX) : wr_data_i[PRES_W-1:0];
                act1_q <= wdt_action_t'(wr_data_i[5:4]);
                act2_q <= wdt_action_t'(wr_data_i[7:6]);
                pd_q   <= wr_data_i[8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q  <= 1'b0;
            irq_q  <= 1'b0;
            smi_q  <= 1'b0;
            rstf_q <= 1'b0;
        end else begin
            if (wr_sts && wr_data_i[0])  ovf_q <= 1'b0;
            if (wr_sts && !wr_data_i[0]) begin
                irq_q  <= 1'b0;
                smi_q  <= 1'b0;
                rstf_q <= 1'b0;
            end
            if (fire1) ovf_q <= 1'b1;
            unique case (fired)
                ACT_NONE:  ;
                ACT_IRQ:   irq_q  <= 1'b1;
                ACT_SMI:   smi_q  <= 1'b1;
                ACT_RESET: rstf_q <= 1'b1;
            endcase
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (addr_i == ADDR_W'(ADR_TIMEOUT)) rd_data_o[CNT_W-1:0] = timeout_q;
        else if (addr_i == ADDR_W'(ADR_CONFIG))
            rd_data_o[8:0] = {pd_q, act2_q, act1_q, 4'(pres_q)};
        else if (addr_i == ADDR_W'(ADR_STATUS))
            rd_data_o[3:0] = {rstf_q, smi_q, irq_q, ovf_q};
    end

    assign irq_o     = irq_q;
    assign smi_o     = smi_q;
    assign rst_req_o = rstf_q;
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
    parameter int PRES_W   = 4,
    parameter int PRES_MAX = 13,
    parameter int ADDR_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [15:0]       wr_data_i,
    input logic              irq_o,
    input logic              smi_o,
    input logic              rst_req_o,
    input logic [PRES_W-1:0] pres_q,
    input logic              pd_q,
    input logic              ovf_q
);
    logic sts_wr0;
    assign sts_wr0 = wr_en_i && (addr_i == ADDR_W'(4)) && !wr_data_i[0];

    assert_pres_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pres_q <= PRES_W'(PRES_MAX));

    assert_pd_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(!pd_q && tick_i));

    assert_irq_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(tick_i));

    assert_smi_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_o) |-> $past(tick_i));

    assert_rst_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o && !sts_wr0) |=> rst_req_o);

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !sts_wr0) |=> irq_o);
endmodule

bind wdt_two_stage wdt_two_stage_chk #(
    .PRES_W(PRES_W), .PRES_MAX(PRES_MAX), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .irq_o(irq_o), .smi_o(smi_o),
    .rst_req_o(rst_req_o), .pres_q(pres_q), .pd_q(pd_q), .ovf_q(ovf_q)
);

// File: tb/sim_wdt_two_stage.sv
module sim_wdt_two_stage;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] rd_data_o;
    logic        irq_o, smi_o, rst_req_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_two_stage u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
        .irq_o(irq_o), .smi_o(smi_o), .rst_req_o(rst_req_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    function automatic logic [15:0] outs();
        return {13'd0, rst_req_o, smi_o, irq_o};
    endfunction

    task automatic clear_all();
        wr(3'h4, 16'h0001);
        wr(3'h4, 16'h0000);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(3'h0, d); check("R1 timeout", d, 16'h0);
        rd(3'h2, d); check("R1 config", d, 16'h0);
        rd(3'h4, d); check("R1 status", d, 16'h0);
        check("R1 outputs", outs(), 16'h0);
    endtask

    task automatic t_config();
        logic [15:0] d;
        wr(3'h2, 16'hFE0E); rd(3'h2, d); check("R3 clamp 0xE / R4 reserved", d, 16'h000D);
        wr(3'h2, 16'h000F); rd(3'h2, d); check("R3 clamp 0xF", d, 16'h000D);
        wr(3'h0, 16'h1234); rd(3'h0, d); check("R2 timeout readback", d, 16'h1234);
        wr(3'h0, 16'h0000);
    endtask

    task automatic t_two_stages();
        logic [15:0] d;
        wr(3'h2, 16'h00D0);
        wr(3'h0, 16'd3);
        ticks(2); check("R6 before stage-1 end", outs(), 16'h0);
        ticks(1); rd(3'h4, d); check("R6 stage-1 irq+ovf", d, 16'h0003);
        ticks(2); check("R7 before stage-2 end", outs(), 16'h1);
        ticks(1); rd(3'h4, d); check("R7 stage-2 reset", d, 16'h000B);
        check("R8 outputs follow status", outs(), 16'h5);
        wr(3'h4, 16'h0001); rd(3'h4, d); check("R9 write1 clears ovf only", d, 16'h000A);
        ticks(4); rd(3'h4, d); check("R7 spent stays quiet", d, 16'h000A);
        wr(3'h4, 16'h0000); rd(3'h4, d); check("R9 write0 clears events", d, 16'h0000);
        check("R9 outputs cleared", outs(), 16'h0);
    endtask

    task automatic t_prescale();
        logic [15:0] d;
        wr(3'h2, 16'h0022);
        wr(3'h0, 16'd1);
        ticks(3); check("R3 divide by 4 not yet", outs(), 16'h0);
        ticks(1); rd(3'h4, d); check("R3 smi after 4 ticks", d, 16'h0005);
        wr(3'h0, 16'h0000); clear_all();
    endtask

    task automatic t_reload();
        logic [15:0] d;
        wr(3'h2, 16'h0050);
        wr(3'h0, 16'd2);
        ticks(1);
        wr(3'h0, 16'd2);
        ticks(1); check("R5 reload restarts count", outs(), 16'h0);
        ticks(1); check("R5 stage-1 after reload", outs(), 16'h1);
        clear_all();
        wr(3'h0, 16'd2);
        ticks(2); rd(3'h4, d); check("R5 reload in stage 2 back to stage 1", d, 16'h0003);
        clear_all();
    endtask

    task automatic t_zero_and_pd();
        logic [15:0] d;
        wr(3'h0, 16'd0);
        ticks(6); rd(3'h4, d); check("R5 zero disables", d, 16'h0000);
        wr(3'h2, 16'h0110);
        wr(3'h0, 16'd1);
        ticks(5); rd(3'h4, d); check("R4 power-down halts", d, 16'h0000);
        wr(3'h2, 16'h0010);
        ticks(1); rd(3'h4, d); check("R4 resumes after power-up", d, 16'h0003);
        clear_all();
    endtask

    task automatic t_no_action();
        logic [15:0] d;
        wr(3'h2, 16'h0000);
        wr(3'h0, 16'd1);
        ticks(1); rd(3'h4, d); check("R8 action 00 sets only ovf", d, 16'h0001);
        check("R8 no request outputs", outs(), 16'h0);
        wr(3'h0, 16'd0); clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_two_stages();
        t_prescale();
        t_reload();
        t_zero_and_pd();
        t_no_action();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule